// File: doc/BRIEF.md
# Clock-Generator Configuration Register Slave

This block is a two-wire (I2C/SMBus) slave that owns the configuration byte bank of a programmable clock generator. A controller updates the bank with block writes only. After the 7-bit device address and the write bit, the controller sends two bytes that the protocol requires (a command byte and a byte count). The slave acknowledges both and discards their values. Every byte after them goes to the next register, starting at register 0. The controller may end the transfer with a Stop after any whole byte.

Two register pairs hold multi-byte settings that must never be seen half updated: a divider pair and a spread-amount pair. The low byte of each pair waits in a staging register. It reaches the live bank only together with the high byte, in the same transfer. One register sets how many bytes a block read returns, and it refuses zero. Another holds a fixed identity byte. The live contents of every register are driven out as one flat vector for the clock logic.

SCL and SDA pass through two-flop synchronisers and are edge-detected on the system clock. The slave only ever pulls SDA low.

Top module: `clkcfg_smbus_slave`

## Requirements
- R1: The slave pulls SDA low in the acknowledge slot after its own 7-bit address (default 7'h69). For any other address it leaves SDA released, and the following bytes change no register.
- R2: In a write transfer, the first two bytes after the address are acknowledged and their values are discarded. The third byte lands in register 0, and each later byte lands in the next higher register.
- R3: Data bytes beyond the last register (index 20 with the default 21 registers) are acknowledged and discarded.
- R4: Register 11 changes only when register 12 is written in the same transfer, and then both change together. A Stop after register 11 leaves both unchanged.
- R5: Registers 13 and 14 form a pair with the same all-or-nothing behaviour as R4.
- R6: Register 8 (read length) keeps its previous value when 0x00 is written to it. It takes any nonzero byte written to it.
- R7: Register 7 always reads {4'b1001, revision}, and writes to it are ignored.
- R8: After reset: register 8 = 0x08, register 9 = 0x10, register 7 = the identity byte, all other registers = 0x00, and SDA is released.
- R9: After the address with the read bit, the slave sends the value of register 8 (N), then registers 0 to N-1, MSB first, N+1 bytes in all. It then releases SDA, even if the controller acknowledges the last byte.
- R10: The slave changes its SDA drive only after a synchronised SCL falling edge, or when it sees a Start or a Stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| cfg_flat | output | NREG*8 | Live register bank, register i at bits [8i+7:8i] |

## Verification
The bench keeps the default 21-register bank, address and pair positions, and sets the revision to 5, so a correct identity byte reads 0x95 rather than a value the design might fall back to by accident. With 21 registers, a 25-byte write runs past the end of the bank, and transfers stopped after 12 or 14 data bytes end exactly between the two halves of each pair. A read length of 4 is short enough that one extra clocked byte shows whether SDA is released after the counted bytes.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_RX,
    LK_RXACK,
    LK_TX,
    LK_TXACK
  } link_st_t;
endpackage

// File: rtl/cfgslv_pin_sync.sv
module cfgslv_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_p, sda_p;
  logic       scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_p  <= scl_ff[1];
      sda_p  <= sda_ff[1];
    end
  end

  assign scl_s     = scl_ff[1];
  assign sda_s     = sda_ff[1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/cfgslv_link.sv
module cfgslv_link
  import cfgslv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NREG     = 21,
  parameter int         IW       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] cnt_val,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] rd_idx,
  output logic              wr_en,
  output logic [IW-1:0]     wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  localparam logic [7:0] LAST_SLOT = 8'(NREG + 1);

  link_st_t    st_q, st_d;
  logic [3:0]  bit_q, bit_d;
  logic [7:0]  sh_q, sh_d;
  logic [7:0]  idx_q, idx_d;
  logic [7:0]  txn_q, txn_d;
  logic        first_q, first_d;
  logic        rd_q, rd_d;
  logic        mack_q, mack_d;
  logic        oe_q, oe_d;
  logic        tx_load;
  logic [7:0]  load_idx;
  logic [7:0]  tx_byte;

  assign rd_idx  = load_idx - 8'd1;
  assign tx_byte = (load_idx == 8'd0) ? cnt_val : rd_data;
  assign wr_idx  = IW'(idx_q - 8'd2);
  assign wr_data = sh_q;
  assign sda_oe  = oe_q;

  always_comb begin
    st_d     = st_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    idx_d    = idx_q;
    txn_d    = txn_q;
    first_d  = first_q;
    rd_d     = rd_q;
    mack_d   = mack_q;
    oe_d     = oe_q;
    wr_en    = 1'b0;
    tx_load  = 1'b0;
    load_idx = txn_q + 8'd1;
    if (start_det) begin
      st_d    = LK_RX;
      bit_d   = 4'd0;
      first_d = 1'b1;
      idx_d   = 8'd0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      st_d = LK_IDLE;
      oe_d = 1'b0;
    end else begin
      case (st_q)
        LK_RX: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            if (first_q) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                oe_d = 1'b1;
                rd_d = sh_q[0];
                st_d = LK_RXACK;
              end else begin
                st_d = LK_IDLE;
              end
            end else begin
              oe_d  = 1'b1;
              st_d  = LK_RXACK;
              wr_en = (idx_q >= 8'd2) && (idx_q <= LAST_SLOT);
              if (idx_q != 8'hFF) idx_d = idx_q + 8'd1;
            end
          end
        end
        LK_RXACK: begin
          if (scl_fall) begin
            first_d = 1'b0;
            bit_d   = 4'd0;
            if (rd_q && first_q) begin
              load_idx = 8'd0;
              tx_load  = 1'b1;
              txn_d    = 8'd0;
              st_d     = LK_TX;
            end else begin
              oe_d = 1'b0;
              st_d = LK_RX;
            end
          end
        end
        LK_TX: begin
          if (scl_fall) begin
            if (bit_q == 4'd8) begin
              oe_d = 1'b0;
              st_d = LK_TXACK;
            end else begin
              oe_d  = ~sh_q[7];
              sh_d  = {sh_q[6:0], 1'b0};
              bit_d = bit_q + 4'd1;
            end
          end
        end
        LK_TXACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q && txn_q < cnt_val) begin
              tx_load = 1'b1;
              txn_d   = txn_q + 8'd1;
              st_d    = LK_TX;
            end else begin
              st_d = LK_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
    if (tx_load) begin
      oe_d  = ~tx_byte[7];
      sh_d  = {tx_byte[6:0], 1'b0};
      bit_d = 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= LK_IDLE;
      bit_q   <= 4'd0;
      sh_q    <= 8'd0;
      idx_q   <= 8'd0;
      txn_q   <= 8'd0;
      first_q <= 1'b0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      idx_q   <= idx_d;
      txn_q   <= txn_d;
      first_q <= first_d;
      rd_q    <= rd_d;
      mack_q  <= mack_d;
      oe_q    <= oe_d;
    end
  end
endmodule

// File: rtl/cfgslv_bank.sv
module cfgslv_bank
  import cfgslv_pkg::*;
#(
  parameter int         NREG    = 21,
  parameter int         IW      = 5,
  parameter int         ID_IDX  = 7,
  parameter logic [7:0] ID_VAL  = 8'h92,
  parameter int         CNT_IDX = 8,
  parameter logic [7:0] CNT_DEF = 8'h08,
  parameter int         TMR_IDX = 9,
  parameter logic [7:0] TMR_DEF = 8'h10,
  parameter int         PAIR_A  = 11,
  parameter int         PAIR_B  = 13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IW-1:0]          wr_idx,
  input  logic [BYTE_W-1:0]      wr_data,
  input  logic [BYTE_W-1:0]      rd_idx,
  output logic [BYTE_W-1:0]      rd_data,
  output logic [BYTE_W-1:0]      cnt_val,
  output logic [NREG*BYTE_W-1:0] cfg_flat
);
  localparam int NPAIR = 2;
  localparam int PLO [NPAIR] = '{PAIR_A, PAIR_B};

  logic [7:0] live_q [NREG];
  logic [7:0] live_d [NREG];
  logic [7:0] stg_q  [NPAIR];
  logic [7:0] stg_d  [NPAIR];

  function automatic logic [7:0] def_val(input int i);
    if (i == ID_IDX)  return ID_VAL;
    if (i == CNT_IDX) return CNT_DEF;
    if (i == TMR_IDX) return TMR_DEF;
    return 8'h00;
  endfunction

  always_comb begin
    for (int i = 0; i < NREG; i++) live_d[i] = live_q[i];
    for (int p = 0; p < NPAIR; p++) stg_d[p] = stg_q[p];
    for (int i = 0; i < NREG; i++) begin
      if (wr_en && wr_idx == IW'(i)) begin
        if (i == CNT_IDX) begin
          if (wr_data != 8'h00) live_d[i] = wr_data;
        end else if (i == PLO[0]) begin
          stg_d[0] = wr_data;
        end else if (i == PLO[1]) begin
          stg_d[1] = wr_data;
        end else if (i == PLO[0] + 1) begin
          live_d[PLO[0]] = stg_q[0];
          live_d[i]      = wr_data;
        end else if (i == PLO[1] + 1) begin
          live_d[PLO[1]] = stg_q[1];
          live_d[i]      = wr_data;
        end else if (i != ID_IDX) begin
          live_d[i] = wr_data;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) live_q[i] <= def_val(i);
      for (int p = 0; p < NPAIR; p++) stg_q[p] <= 8'h00;
    end else begin
      for (int i = 0; i < NREG; i++) live_q[i] <= live_d[i];
      for (int p = 0; p < NPAIR; p++) stg_q[p] <= stg_d[p];
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == 8'(i)) rd_data = live_q[i];
  end

  assign cnt_val = live_q[CNT_IDX];

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign cfg_flat[g*BYTE_W +: BYTE_W] = live_q[g];
  end
endmodule

// File: rtl/clkcfg_smbus_slave.sv
module clkcfg_smbus_slave
  import cfgslv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         NREG      = 21,
  parameter logic [3:0] ID_VENDOR = 4'b1001,
  parameter logic [3:0] ID_REV    = 4'h2,
  parameter int         ID_IDX    = 7,
  parameter int         CNT_IDX   = 8,
  parameter int         TMR_IDX   = 9,
  parameter int         PAIR_A    = 11,
  parameter int         PAIR_B    = 13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  output logic [NREG*BYTE_W-1:0] cfg_flat
);
  localparam int         IW     = $clog2(NREG);
  localparam logic [7:0] ID_VAL = {ID_VENDOR, ID_REV};

  logic [1:0]        rst_ff;
  logic              rst_n_s;
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [IW-1:0]     wr_idx;
  logic [7:0]        wr_data, rd_idx, rd_data, cnt_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_n_s = rst_ff[1];

  cfgslv_pin_sync u_sync (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  cfgslv_link #(.DEV_ADDR(DEV_ADDR), .NREG(NREG), .IW(IW)) u_link (
    .clk(clk), .rst_n(rst_n_s), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .cnt_val(cnt_val), .rd_data(rd_data), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  cfgslv_bank #(
    .NREG(NREG), .IW(IW), .ID_IDX(ID_IDX), .ID_VAL(ID_VAL),
    .CNT_IDX(CNT_IDX), .CNT_DEF(8'h08), .TMR_IDX(TMR_IDX), .TMR_DEF(8'h10),
    .PAIR_A(PAIR_A), .PAIR_B(PAIR_B)
  ) u_bank (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .cnt_val(cnt_val), .cfg_flat(cfg_flat)
  );
endmodule

// File: rtl/cfgslv_chk.sv
module cfgslv_chk #(
  parameter int         NREG    = 21,
  parameter int         IW      = 5,
  parameter int         ID_IDX  = 7,
  parameter logic [7:0] ID_VAL  = 8'h92,
  parameter int         CNT_IDX = 8,
  parameter int         PAIR_A  = 11,
  parameter int         PAIR_B  = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input logic              wr_en,
  input logic [IW-1:0]     wr_idx,
  input logic [7:0]        wr_data,
  input logic [NREG*8-1:0] cfg_flat
);
  // R10
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

  // R4
  pair_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_flat[PAIR_A*8 +: 8]) |-> $past(wr_en && wr_idx == IW'(PAIR_A + 1)));

  // R5
  pair_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_flat[PAIR_B*8 +: 8]) |-> $past(wr_en && wr_idx == IW'(PAIR_B + 1)));

  // R6
  cnt_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_flat[CNT_IDX*8 +: 8]) |-> $past(wr_en && wr_idx == IW'(CNT_IDX) && wr_data != 8'h00));

  // R7
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_flat[ID_IDX*8 +: 8] == ID_VAL);

  // R3
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < IW'(NREG)));
endmodule

bind clkcfg_smbus_slave cfgslv_chk #(
  .NREG(NREG), .IW(IW), .ID_IDX(ID_IDX), .ID_VAL(ID_VAL),
  .CNT_IDX(CNT_IDX), .PAIR_A(PAIR_A), .PAIR_B(PAIR_B)
) u_chk (
  .clk(clk), .rst_n(rst_n_s), .sda_oe(sda_oe), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .wr_en(wr_en),
  .wr_idx(wr_idx), .wr_data(wr_data), .cfg_flat(cfg_flat)
);

// File: tb/sim_clkcfg_smbus_slave.sv
module sim_clkcfg_smbus_slave;
  localparam int         NREG = 21;
  localparam logic [6:0] ADDR = 7'h69;
  localparam int         Q    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [NREG*8-1:0] cfg;
  logic [7:0] wbuf [32];
  logic [7:0] exp_r [NREG];
  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  clkcfg_smbus_slave #(.ID_REV(4'h5)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .cfg_flat(cfg)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++)
      chk(req, $sformatf("reg%0d", i), {24'd0, cfg[i*8 +: 8]}, {24'd0, exp_r[i]});
  endtask

  task automatic wbit(input logic b);
    tick(Q); sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
  endtask

  task automatic rbit(output logic b);
    tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_bus; tick(Q); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(a);
    ack = ~a;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(~ack);
  endtask

  // Block write of n data bytes from wbuf; updates the model when addressed to ADDR.
  task automatic blk_write(input string req, input logic [6:0] addr, input int n);
    logic ack;
    int nack = 0;
    bus_start();
    wbyte({addr, 1'b0}, ack);
    if (addr == ADDR) begin
      chk("R1", "own address ack", {31'd0, ack}, 32'd1);
      wbyte(8'hAA, ack); if (!ack) nack++;
      wbyte(8'h03, ack); if (!ack) nack++;
      for (int i = 0; i < n; i++) begin wbyte(wbuf[i], ack); if (!ack) nack++; end
      chk(req, "data byte nacks", nack, 32'd0);
    end else begin
      chk("R1", "foreign address nack", {31'd0, ack}, 32'd0);
      for (int i = 0; i < n; i++) wbyte(wbuf[i], ack);
    end
    bus_stop();
    if (addr == ADDR) begin
      for (int i = 0; i < n && i < NREG; i++) begin
        if (i == 7 || i == 11 || i == 13) continue;
        if (i == 8) begin
          if (wbuf[i] != 8'h00) exp_r[8] = wbuf[i];
        end else if (i == 12 || i == 14) begin
          exp_r[i-1] = wbuf[i-1];
          exp_r[i]   = wbuf[i];
        end else begin
          exp_r[i] = wbuf[i];
        end
      end
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < NREG; i++) exp_r[i] = 8'h00;
    exp_r[7] = 8'h95;
    exp_r[8] = 8'h08;
    exp_r[9] = 8'h10;
    check_regs("R8");
    chk("R8", "sda released", {31'd0, sda_oe}, 32'd0);
  endtask

  task automatic t_block_write();
    for (int i = 0; i < 6; i++) wbuf[i] = 8'h10 + 8'(i);
    blk_write("R2", ADDR, 6);
    chk("R2", "reg0 holds first data byte", {24'd0, cfg[7:0]}, 32'h10);
    check_regs("R2");
  endtask

  task automatic t_wrong_addr();
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hE0 + 8'(i);
    blk_write("R1", 7'h2A, 4);
    check_regs("R1");
  endtask

  task automatic t_pair_a();
    for (int i = 0; i < 32; i++) wbuf[i] = 8'hA0 + 8'(i);
    wbuf[8] = 8'h00;
    blk_write("R4", ADDR, 12);
    chk("R4", "reg11 held after lone low byte", {24'd0, cfg[11*8 +: 8]}, 32'h00);
    chk("R6", "zero write to reg8 ignored", {24'd0, cfg[8*8 +: 8]}, 32'h08);
    chk("R7", "id ignores write", {24'd0, cfg[7*8 +: 8]}, 32'h95);
    check_regs("R4");
    blk_write("R4", ADDR, 13);
    chk("R4", "reg11 committed with reg12", {24'd0, cfg[11*8 +: 8]}, 32'hAB);
    chk("R4", "reg12 committed", {24'd0, cfg[12*8 +: 8]}, 32'hAC);
  endtask

  task automatic t_pair_b();
    for (int i = 0; i < 32; i++) wbuf[i] = 8'hC0 + 8'(i);
    wbuf[8] = 8'h00;
    blk_write("R5", ADDR, 14);
    chk("R5", "reg13 held after lone low byte", {24'd0, cfg[13*8 +: 8]}, 32'h00);
    check_regs("R5");
    blk_write("R5", ADDR, 15);
    chk("R5", "reg13 committed with reg14", {24'd0, cfg[13*8 +: 8]}, 32'hCD);
    check_regs("R5");
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 32; i++) wbuf[i] = 8'h30 + 8'(i);
    wbuf[8] = 8'h00;
    blk_write("R3", ADDR, 25);
    check_regs("R3");
  endtask

  task automatic t_count();
    for (int i = 0; i < 9; i++) wbuf[i] = 8'h50 + 8'(i);
    wbuf[7] = 8'h00;
    wbuf[8] = 8'h04;
    blk_write("R6", ADDR, 9);
    chk("R6", "nonzero reg8 stored", {24'd0, cfg[8*8 +: 8]}, 32'h04);
    chk("R7", "id ignores zero write", {24'd0, cfg[7*8 +: 8]}, 32'h95);
    check_regs("R6");
  endtask

  task automatic t_read();
    logic ack;
    logic [7:0] d;
    bus_start();
    wbyte({ADDR, 1'b1}, ack);
    chk("R1", "read address ack", {31'd0, ack}, 32'd1);
    rbyte(d, 1'b1);
    chk("R9", "count byte first", {24'd0, d}, 32'h04);
    for (int i = 0; i < 4; i++) begin
      rbyte(d, 1'b1);
      chk("R9", $sformatf("readback reg%0d", i), {24'd0, d}, {24'd0, exp_r[i]});
    end
    rbyte(d, 1'b0);
    chk("R9", "released after counted bytes", {24'd0, d}, 32'hFF);
    bus_stop();
    chk("R9", "sda idle after read", {31'd0, sda_oe}, 32'd0);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_block_write();
    t_wrong_addr();
    t_pair_a();
    t_pair_b();
    t_overrun();
    t_count();
    t_read();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule